// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Block with Interrupt Detection

This block drives and samples up to 32 general-purpose pins. Software reaches it over a simple 32-bit register bus with word-aligned addresses. Every pin has a control word of its own. The control word switches the pin's output, input and output buffer on or off, arms its interrupt, and selects one of five trigger conditions: high level, low level, rising edge, falling edge, or any edge. Three shared words hold the latched interrupt events, the synchronised input levels and the levels driven onto the pins.

Each pin input passes through a two-stage synchroniser before any logic uses it. The detector of each pin compares the synchronised level with the level one clock earlier, and latches a hit in a sticky pending bit. Software clears a pending bit by writing 1 to it. A single interrupt line goes high when any pending bit belongs to a pin whose interrupt is armed.

A read returns its data one clock after the request. A read request and a write request never occur in the same cycle.

Top module: `pinbank_gpio`

## Requirements
- R1: The control word of pin i is at byte offset 4*i. It stores written bits 0 (output enable), 1 (input enable), 2 (buffer enable), 3 (interrupt arm) and 7:5 (trigger code). Bit 4 and bits 31:8 read as zero. A write changes only the addressed pin.
- R2: `pin_oe[i]` is 1 exactly when bits 0 and 2 of pin i's control word are both set. It follows the control word one clock after that word changes.
- R3: A write to offset 0x88 loads the driven levels from the low pin bits. `pin_out` shows them after that same clock edge, and reads of 0x88 return them.
- R4: Offset 0x84 returns, for each pin whose bit 1 is set, its input level delayed by two clocks of synchronisation; all other pins read 0. Writes to 0x84 have no effect.
- R5: Trigger code 0 latches pending while the synchronised level is 1, and code 1 latches it while the level is 0. A level still asserted sets the bit again on the cycle after it is cleared.
- R6: Code 2 latches on a 0-to-1 change of the synchronised level, code 3 on a 1-to-0 change, and code 4 on either change. Codes 5, 6 and 7 never latch.
- R7: Offset 0x80 holds one pending bit per pin. Writing 1 to a bit clears it, and bits written 0 keep their value. If an event arrives in the same cycle as its clear, the bit stays set.
- R8: `irq` is a register that goes to 1 one clock after any pending bit is set on a pin whose bit 3 is set. It is 0 when no pending bit is armed.
- R9: Reads of offsets 0x8C to 0xFC, and of control words of pins at or above the implemented count, return 0. Writes to those offsets change nothing.
- R10: Reset clears every control word, the pending bits, the driven levels, `pin_oe`, `irq` and the read data.
- R11: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NP | Asynchronous pin levels |
| pin_out | output | NP | Driven pin levels |
| pin_oe | output | NP | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The event detector and the software clear both act on the same pending bit, and they can meet at one clock edge. To provoke this, the bench toggles a pin set to any-edge triggering. It then times a write-1-to-clear so that the write is sampled on the very edge where the synchronised edge reaches the detector. The pending bit must stay set. A cycle-accurate reference model judges the outcome, and a directed readback confirms it. Level triggers add a second overlap: a clear against a level that is still asserted must be followed at once by the bit setting again.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int PB_MAX_PINS = 32;
  localparam int PB_ADDR_W   = 8;

  // word indices (byte offset / 4) of the shared words
  localparam logic [5:0] PB_W_PEND  = 6'h20;
  localparam logic [5:0] PB_W_LEVEL = 6'h21;
  localparam logic [5:0] PB_W_DRIVE = 6'h22;

  localparam logic [2:0] TRIG_HIGH = 3'd0;
  localparam logic [2:0] TRIG_LOW  = 3'd1;
  localparam logic [2:0] TRIG_RISE = 3'd2;
  localparam logic [2:0] TRIG_FALL = 3'd3;
  localparam logic [2:0] TRIG_ANY  = 3'd4;

  typedef struct packed {
    logic [2:0] trig;
    logic       irq_arm;
    logic       buf_en;
    logic       in_en;
    logic       out_en;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_unpack(input logic [7:0] w);
    pin_cfg_t c;
    c.trig    = w[7:5];
    c.irq_arm = w[3];
    c.buf_en  = w[2];
    c.in_en   = w[1];
    c.out_en  = w[0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_pack(input pin_cfg_t c);
    return {c.trig, 1'b0, c.irq_arm, c.buf_en, c.in_en, c.out_en};
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
  import pinbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wd,
  input  logic       clr,
  output logic [7:0] cfg_word,
  output logic       pend
);
  pin_cfg_t cfg;
  logic     prev;
  logic     hit;

  always_comb begin
    case (cfg.trig)
      TRIG_HIGH: hit = lvl;
      TRIG_LOW:  hit = ~lvl;
      TRIG_RISE: hit = lvl & ~prev;
      TRIG_FALL: hit = ~lvl & prev;
      TRIG_ANY:  hit = lvl ^ prev;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= lvl;
      if (cfg_we) cfg <= cfg_unpack(cfg_wd);
      pend <= (pend & ~clr) | hit;
    end
  end

  assign cfg_word = cfg_pack(cfg);
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter  int NPINS = 32,
  localparam int NP    = (NPINS > PB_MAX_PINS) ? PB_MAX_PINS : NPINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [PB_ADDR_W-1:0] bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NP-1:0]        pin_in,
  output logic [NP-1:0]        pin_out,
  output logic [NP-1:0]        pin_oe,
  output logic                 irq
);
  logic [5:0]          word;
  logic [4:0]          pidx;
  logic                ctrl_sel, sel_pend, sel_level, sel_drive;
  logic [NP-1:0]       lvl, pend_v, ie_v, oe_req, in_en_v;
  logic [NP-1:0][7:0]  cfg_word;
  logic [31:0]         rd_mux;

  assign word      = bus_addr[7:2];
  assign pidx      = bus_addr[6:2];
  assign ctrl_sel  = !bus_addr[7] && (int'(pidx) < NP);
  assign sel_pend  = (word == PB_W_PEND);
  assign sel_level = (word == PB_W_LEVEL);
  assign sel_drive = (word == PB_W_DRIVE);

  pinbank_sync #(.W(NP), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl)
  );

  for (genvar g = 0; g < NP; g++) begin : g_pin
    pinbank_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl[g]),
      .cfg_we   (bus_wr && ctrl_sel && (pidx == 5'(g))),
      .cfg_wd   (bus_wdata[7:0]),
      .clr      (bus_wr && sel_pend && bus_wdata[g]),
      .cfg_word (cfg_word[g]),
      .pend     (pend_v[g])
    );
    assign ie_v[g]    = cfg_word[g][3];
    assign oe_req[g]  = cfg_word[g][0] & cfg_word[g][2];
    assign in_en_v[g] = cfg_word[g][1];
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_sel) begin
      for (int i = 0; i < NP; i++)
        if (pidx == 5'(i)) rd_mux = {24'b0, cfg_word[i]};
    end else if (sel_pend) begin
      rd_mux = 32'(pend_v);
    end else if (sel_level) begin
      rd_mux = 32'(lvl & in_en_v);
    end else if (sel_drive) begin
      rd_mux = 32'(pin_out);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_out   <= '0;
      pin_oe    <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && sel_drive) pin_out <= bus_wdata[NP-1:0];
      pin_oe <= oe_req;
      irq    <= |(pend_v & ie_v);
    end
  end
endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
  parameter int NP = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NP-1:0]      pin_out,
  input logic [NP-1:0]      pin_oe,
  input logic               irq,
  input logic [NP-1:0]      pend_v,
  input logic [NP-1:0]      ie_v,
  input logic [NP-1:0][7:0] cfg_word
);
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(pend_v & ie_v)));

  assert_drive_load_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[7:2] == 6'h22) |=> (pin_out == $past(bus_wdata[NP-1:0])));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= 8'h8C) |=> (bus_rdata == 32'd0));

  for (genvar g = 0; g < NP; g++) begin : g_chk
    assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_v[g]) |-> ($past(cfg_word[g][7:5]) <= 3'd4));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr[7:2] == 6'h20 && bus_wdata[g] && cfg_word[g][7:5] > 3'd4)
      |=> !pend_v[g]);

    assert_oe_gate_R2: assert property (@(posedge clk) disable iff (rst)
      pin_oe[g] |-> $past(cfg_word[g][0] && cfg_word[g][2]));
  end
endmodule

bind pinbank_gpio pinbank_gpio_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .pend_v    (pend_v),
  .ie_v      (ie_v),
  .cfg_word  (cfg_word)
);

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  pinbank_gpio #(.NPINS(N)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_s1, m_s2, m_prev, m_pend, m_drive, m_oe;
  logic        m_irq;
  logic [31:0] m_rd;
  logic [7:0]  m_cfg [N];

  function automatic logic m_hit(int i);
    case (m_cfg[i][7:5])
      3'd0: return m_s2[i];
      3'd1: return !m_s2[i];
      3'd2: return m_s2[i] && !m_prev[i];
      3'd3: return !m_s2[i] && m_prev[i];
      3'd4: return m_s2[i] != m_prev[i];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int w = int'(a) / 4;
    logic [7:0] lv;
    for (int i = 0; i < N; i++) lv[i] = m_s2[i] && m_cfg[i][1];
    if (w < N)   return {24'b0, m_cfg[w]};
    if (w < 32)  return 32'd0;
    if (w == 32) return {24'b0, m_pend};
    if (w == 33) return {24'b0, lv};
    if (w == 34) return {24'b0, m_drive};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nx_pend, nx_oe;
    logic       nx_irq;
    int         w;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_drive = '0;
      m_oe = '0; m_irq = 1'b0; m_rd = '0;
      for (int i = 0; i < N; i++) m_cfg[i] = '0;
    end else begin
      nx_irq = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (m_pend[i] && m_cfg[i][3]) nx_irq = 1'b1;
        nx_oe[i]   = m_cfg[i][0] && m_cfg[i][2];
        nx_pend[i] = (m_pend[i] && !(bus_wr && bus_addr[7:2] == 6'h20 && bus_wdata[i]))
                     || m_hit(i);
      end
      if (bus_rd) m_rd = m_read(bus_addr);
      if (bus_wr) begin
        w = int'(bus_addr) / 4;
        if (w < N)  m_cfg[w] = bus_wdata[7:0] & 8'hEF;
        if (w == 34) m_drive = bus_wdata[7:0];
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      m_pend = nx_pend; m_irq = nx_irq; m_oe = nx_oe;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 rdata vs model", bus_rdata, m_rd);
      chk("R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk("R3 pin_out vs model", {24'b0, pin_out}, {24'b0, m_drive});
      chk("R2 pin_oe vs model", {24'b0, pin_oe}, {24'b0, m_oe});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=%0d expected<50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 pin_oe", {24'b0, pin_oe}, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'd0);
    chk("R10 pin_out", {24'b0, pin_out}, 32'd0);
    rd(8'h00, 32'd0, "R10 ctrl0");
    rd(8'h80, 32'd0, "R10 pend");
    rd(8'h84, 32'd0, "R10 level");
    rd(8'h88, 32'd0, "R10 drive");
    // R1 control words
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_00EF, "R1 ctrl0 stored bits");
    rd(8'h04, 32'd0, "R1 ctrl1 untouched");
    wr(8'h04, 32'hFFFF_FF10);
    rd(8'h04, 32'd0, "R1 bit4 and upper dropped");
    // R9 unmapped
    wr(8'h24, 32'hFF);
    rd(8'h24, 32'd0, "R9 ctrl above pin count");
    rd(8'h8C, 32'd0, "R9 offset 0x8C");
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, 32'd0, "R9 offset 0x90");
    rd(8'hFC, 32'd0, "R9 offset 0xFC");
    rd(8'h1C, 32'd0, "R9 ctrl7 unaffected");
    // R3 driven levels, R11 hold
    wr(8'h88, 32'hA5);
    chk("R3 pin_out after write", {24'b0, pin_out}, 32'hA5);
    rd(8'h88, 32'hA5, "R3 drive readback");
    idle(2);
    chk("R11 rdata holds", bus_rdata, 32'hA5);
    wr(8'h88, 32'hFFFF_FF5A);
    rd(8'h88, 32'h5A, "R3 drive low bits only");
    // R2 output enable gating
    chk("R2 pin0 oe", {24'b0, pin_oe}, 32'h01);
    wr(8'h08, 32'h01); idle(1);
    chk("R2 no buffer no oe", {24'b0, pin_oe}, 32'h01);
    wr(8'h08, 32'h05); idle(1);
    chk("R2 oe with buffer", {24'b0, pin_oe}, 32'h05);
    wr(8'h08, 32'h04); idle(1);
    chk("R2 oe dropped", {24'b0, pin_oe}, 32'h01);
    // R4 input levels
    wr(8'h84, 32'hFF);
    rd(8'h84, 32'd0, "R4 write ignored");
    wr(8'h0C, 32'h02);
    pin_in[3] = 1'b1; pin_in[4] = 1'b1;
    idle(3);
    rd(8'h84, 32'h08, "R4 level with input enable only");
    // R5 level triggers
    rd(8'h80, 32'h18, "R5 level high pending");
    wr(8'h80, 32'h08);
    rd(8'h80, 32'h18, "R5 re-set while asserted");
    chk("R8 unarmed no irq", {31'b0, irq}, 32'd0);
    pin_in[3] = 1'b0; pin_in[4] = 1'b0;
    idle(3);
    wr(8'h80, 32'hFF);
    rd(8'h80, 32'd0, "R7 cleared");
    // R6 rising with R8 irq
    wr(8'h14, 32'h4A);
    pin_in[5] = 1'b1; idle(4);
    rd(8'h80, 32'h20, "R6 rising latched");
    chk("R8 irq armed", {31'b0, irq}, 32'd1);
    wr(8'h80, 32'h20);
    rd(8'h80, 32'd0, "R6 edge is one-shot");
    chk("R8 irq dropped", {31'b0, irq}, 32'd0);
    pin_in[5] = 1'b0; idle(4);
    rd(8'h80, 32'd0, "R6 rising ignores fall");
    // falling
    wr(8'h18, 32'h6A);
    pin_in[6] = 1'b1; idle(4);
    rd(8'h80, 32'd0, "R6 falling ignores rise");
    pin_in[6] = 1'b0; idle(4);
    rd(8'h80, 32'h40, "R6 falling latched");
    wr(8'h80, 32'h40);
    // any edge
    wr(8'h1C, 32'h8A);
    pin_in[7] = 1'b1; idle(4);
    rd(8'h80, 32'h80, "R6 any edge rise");
    wr(8'h80, 32'h80);
    rd(8'h80, 32'd0, "R7 any edge cleared");
    pin_in[7] = 1'b0; idle(4);
    rd(8'h80, 32'h80, "R6 any edge fall");
    // R7 event and clear on the same edge
    pin_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h80; bus_wdata = 32'h80;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h80, 32'h80, "R7 event wins over clear");
    wr(8'h80, 32'h7F);
    rd(8'h80, 32'h80, "R7 zero bits keep value");
    wr(8'h80, 32'h80);
    rd(8'h80, 32'd0, "R7 bit cleared");
    // R5 level low
    wr(8'h04, 32'h28); idle(2);
    rd(8'h80, 32'h02, "R5 level low pending");
    chk("R8 irq level low", {31'b0, irq}, 32'd1);
    pin_in[1] = 1'b1; idle(4);
    wr(8'h80, 32'h02);
    rd(8'h80, 32'd0, "R5 level low released");
    chk("R8 irq cleared", {31'b0, irq}, 32'd0);
    // R6 reserved codes
    wr(8'h00, 32'hA0);
    wr(8'h08, 32'hC0);
    pin_in[0] = 1'b1; pin_in[2] = 1'b1; idle(4);
    pin_in[0] = 1'b0; pin_in[2] = 1'b0; idle(4);
    rd(8'h80, 32'd0, "R6 reserved codes never latch");
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule